// File: doc/BRIEF.md
# Multi-mode display host interface

This block is the microcontroller-facing front end of a display controller. A group of shared host pins is given one of three meanings by two static strap inputs. It can be a synchronous serial link with a single bidirectional data pin, an i80-style parallel bus with separate read and write strobes, or an M68-style parallel bus with an enable strobe and a read/write level. The parallel buses can move a byte either in one 8-bit transfer or as two 4-bit nibbles on the upper data lines. A flag supplied by the instruction decoder selects the 4-bit width.

Every host pin passes through a synchronizer into the system clock domain before any edge is detected. Each completed write leaves the block as a one-cycle pulse that carries the byte and an instruction/data flag. For reads, the block shows the core which register the host is addressing, and it drives the byte the core supplies back onto the bus.

Top module: `host_bus_front`

## Requirements
- R1: Strap `par_mode_i` selects serial operation (0) or parallel operation (1), and strap `m68_i` selects the i80 style (0) or the M68 style (1). Strobes of a style that is not selected produce no write pulse and leave `db_oe_o` and `sio_oe_o` low.
- R2: While `cs_ni` is high, strobes produce no write pulse, and `db_oe_o` and `sio_oe_o` stay low.
- R3: In M68 mode with `rw_i`=0, the byte on `db_i` is captured at the falling edge of `e_i`. `rs_i`=0 marks the byte for the instruction register and `rs_i`=1 marks it for the data register.
- R4: In M68 mode with `rw_i`=1, while `e_i` is high, the block drives `rd_data_i` onto `db_o` with `db_oe_o`=1.
- R5: In i80 mode, the byte on `db_i` is captured at the rising edge of `rw_i` (the write strobe), tagged by `rs_i` as in R3.
- R6: In i80 mode, while `e_i` (the read strobe) is low, the block drives `rd_data_i` onto `db_o` with `db_oe_o`=1.
- R7: With `bus4_i`=1, only `db_i[7:4]` is used. The first write strobe supplies the high nibble, and the second supplies the low nibble and completes the byte. Reads drive the high nibble of `rd_data_i` on `db_o[7:4]`, then the low nibble after the first read strobe ends. `db_o[3:0]` is driven 0.
- R8: Reset clears the nibble phase, so the next 4-bit strobe after reset is taken as a high nibble.
- R9: In serial mode, a frame is open while `cs_ni`=0 and `rs_i` (the frame strobe) is low. `sio_i` is sampled at each rising edge of `e_i` (the shift clock). The first bit is read (1) or write (0), the second is data register (1) or instruction register (0), and eight data bits follow, MSB first. A write pulse is produced at the rising edge of the frame strobe only for a write frame of exactly 10 bits.
- R10: In a serial read frame, the block starts driving `sio_o` with `sio_oe_o`=1 once the two control bits have been sampled. It drives `rd_data_i` MSB first and moves to the next bit at each later shift-clock rise. It releases the pin after bit 0 has been shifted out, or when the frame closes.
- R11: `wr_valid_o` is high for exactly one system-clock cycle per completed write, and `wr_data_o` and `wr_is_data_o` hold that write's byte and register flag during the pulse.
- R12: `rd_is_data_o` gives the register the current read addresses: `rs_i` in parallel modes, and the second frame bit in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_mode_i | input | 1 | Strap: 0 serial, 1 parallel |
| m68_i | input | 1 | Strap: 0 i80 style, 1 M68 style |
| bus4_i | input | 1 | 4-bit parallel width flag from the instruction decoder |
| cs_ni | input | 1 | Chip select, active low |
| rs_i | input | 1 | Register select (parallel) or frame strobe (serial) |
| e_i | input | 1 | M68 enable, i80 read strobe, or serial shift clock |
| rw_i | input | 1 | M68 read/write level or i80 write strobe |
| db_i | input | DW | Parallel data bus input |
| db_o | output | DW | Parallel data bus read value |
| db_oe_o | output | 1 | Parallel data bus output enable |
| sio_i | input | 1 | Serial data pin input |
| sio_o | output | 1 | Serial data pin output |
| sio_oe_o | output | 1 | Serial data pin output enable |
| rd_data_i | input | DW | Byte supplied by the core for reads |
| rd_is_data_o | output | 1 | Read targets the data register |
| wr_valid_o | output | 1 | One-cycle write pulse |
| wr_data_o | output | DW | Written byte |
| wr_is_data_o | output | 1 | Written byte targets the data register |

## Verification
The bench uses the default 8-bit data width with two synchronizer stages. This makes every byte value affordable in both 8-bit parallel styles. It then sweeps strided byte sets through the 4-bit styles, serial writes and all four read paths. Each sweep alternates the register-select value, so every capture edge is checked against both register flags. The short width also leaves room for the corner cases: frames one bit short or one bit long, a dangling nibble cut off by reset, strobes of the wrong style, and chip select held high.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int unsigned CTRL_BITS = 2;   // serial: direction bit, then register bit
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    BUS_SERIAL = 2'b00,
    BUS_I80    = 2'b10,
    BUS_M68    = 2'b11
  } bus_kind_e;

  function automatic bus_kind_e decode_bus(input logic par, input logic m68);
    if (!par) return BUS_SERIAL;
    return m68 ? BUS_M68 : BUS_I80;
  endfunction
endpackage

// File: rtl/hbf_pin_sync.sv
module hbf_pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbf_par_port.sv
module hbf_par_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          m68_i,
  input  logic          bus4_i,
  input  logic          cs_n_i,
  input  logic          rs_i,
  input  logic          e_i,
  input  logic          rw_i,
  input  logic [DW-1:0] db_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          evt_o,
  output logic [DW-1:0] byte_o,
  output logic          rs_o,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o
);
  localparam int unsigned NW = DW / 2;

  logic          e_q, rw_q, phase_q;
  logic [NW-1:0] hi_q;
  logic          sel, wr_evt, rd_act, rd_end;

  assign sel = en_i && !cs_n_i;

  always_comb begin
    if (m68_i) begin
      wr_evt = sel && e_q && !e_i && !rw_i;
      rd_act = sel && e_i && rw_i;
      rd_end = sel && e_q && !e_i && rw_i;
    end else begin
      wr_evt = sel && !rw_q && rw_i;
      rd_act = sel && !e_i;
      rd_end = sel && !e_q && e_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q     <= 1'b0;
      rw_q    <= 1'b0;
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      e_q  <= e_i;
      rw_q <= rw_i;
      if (!bus4_i) begin
        phase_q <= 1'b0;
      end else if (wr_evt) begin
        if (!phase_q) hi_q <= db_i[DW-1 -: NW];
        phase_q <= !phase_q;
      end else if (rd_end) begin
        phase_q <= !phase_q;
      end
    end
  end

  assign evt_o  = wr_evt && (!bus4_i || phase_q);
  assign byte_o = bus4_i ? {hi_q, db_i[DW-1 -: NW]} : db_i;
  assign rs_o   = rs_i;

  always_comb begin
    if (!bus4_i)      db_o = rd_data_i;
    else if (phase_q) db_o = {rd_data_i[NW-1:0], {NW{1'b0}}};
    else              db_o = {rd_data_i[DW-1 -: NW], {NW{1'b0}}};
  end
  assign db_oe_o = rd_act;
endmodule

// File: rtl/hbf_ser_port.sv
module hbf_ser_port
  import hbf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cs_n_i,
  input  logic          st_i,
  input  logic          sck_i,
  input  logic          sio_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          evt_o,
  output logic [DW-1:0] byte_o,
  output logic          rs_o,
  output logic          sio_o,
  output logic          sio_oe_o
);
  localparam int unsigned FRAME = CTRL_BITS + DW;
  localparam int unsigned CW    = $clog2(FRAME + 2);

  logic          sck_q, st_q, rd_bit_q, rs_bit_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          frame, sck_rise, in_data;

  assign frame    = en_i && !cs_n_i && !st_i;
  assign sck_rise = frame && !sck_q && sck_i;
  assign in_data  = (cnt_q >= CW'(CTRL_BITS)) && (cnt_q < CW'(FRAME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      st_q     <= 1'b1;
      rd_bit_q <= 1'b0;
      rs_bit_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      sck_q <= sck_i;
      st_q  <= st_i;
      if (!frame) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        if (cnt_q <= CW'(FRAME)) cnt_q <= cnt_q + 1'b1;   // saturates at FRAME+1
        if (cnt_q == '0)       rd_bit_q <= sio_i;
        if (cnt_q == CW'(1))   rs_bit_q <= sio_i;
        if (in_data)           sh_q <= {sh_q[DW-2:0], sio_i};
      end
    end
  end

  assign evt_o  = en_i && !cs_n_i && !st_q && st_i && !rd_bit_q && (cnt_q == CW'(FRAME));
  assign byte_o = sh_q;
  assign rs_o   = rs_bit_q;

  always_comb begin
    sio_o = 1'b0;
    for (int i = 0; i < int'(DW); i++)
      if (cnt_q == CW'(FRAME - 1 - i)) sio_o = rd_data_i[i];
  end
  assign sio_oe_o = frame && rd_bit_q && in_data;
endmodule

// File: rtl/host_bus_front.sv
module host_bus_front
  import hbf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          par_mode_i,
  input  logic          m68_i,
  input  logic          bus4_i,
  input  logic          cs_ni,
  input  logic          rs_i,
  input  logic          e_i,
  input  logic          rw_i,
  input  logic [DW-1:0] db_i,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  input  logic          sio_i,
  output logic          sio_o,
  output logic          sio_oe_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_is_data_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_is_data_o
);
  localparam int unsigned PW = 5 + DW;
  localparam logic [PW-1:0] PIN_RST = {2'b11, {(PW-2){1'b0}}};

  bus_kind_e     kind;
  logic [PW-1:0] pins_s;
  logic          cs_s, rs_s, e_s, rw_s, sio_s;
  logic [DW-1:0] db_s;

  assign kind = decode_bus(par_mode_i, m68_i);

  hbf_pin_sync #(.W(PW), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rs_i, e_i, rw_i, sio_i, db_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, rs_s, e_s, rw_s, sio_s, db_s} = pins_s;

  logic          p_evt, p_rs, p_oe;
  logic [DW-1:0] p_byte, p_db;

  hbf_par_port #(.DW(DW)) u_par (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (kind != BUS_SERIAL),
    .m68_i    (kind == BUS_M68),
    .bus4_i   (bus4_i),
    .cs_n_i   (cs_s),
    .rs_i     (rs_s),
    .e_i      (e_s),
    .rw_i     (rw_s),
    .db_i     (db_s),
    .rd_data_i(rd_data_i),
    .evt_o    (p_evt),
    .byte_o   (p_byte),
    .rs_o     (p_rs),
    .db_o     (p_db),
    .db_oe_o  (p_oe)
  );

  logic          s_evt, s_rs, s_sio, s_oe;
  logic [DW-1:0] s_byte;

  hbf_ser_port #(.DW(DW)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (kind == BUS_SERIAL),
    .cs_n_i   (cs_s),
    .st_i     (rs_s),
    .sck_i    (e_s),
    .sio_i    (sio_s),
    .rd_data_i(rd_data_i),
    .evt_o    (s_evt),
    .byte_o   (s_byte),
    .rs_o     (s_rs),
    .sio_o    (s_sio),
    .sio_oe_o (s_oe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o   <= 1'b0;
      wr_data_o    <= '0;
      wr_is_data_o <= 1'b0;
    end else begin
      wr_valid_o <= (kind == BUS_SERIAL) ? s_evt : p_evt;
      if (kind == BUS_SERIAL && s_evt) begin
        wr_data_o    <= s_byte;
        wr_is_data_o <= s_rs;
      end else if (kind != BUS_SERIAL && p_evt) begin
        wr_data_o    <= p_byte;
        wr_is_data_o <= p_rs;
      end
    end
  end

  assign db_o         = p_db;
  assign db_oe_o      = (kind != BUS_SERIAL) && p_oe;
  assign sio_o        = s_sio;
  assign sio_oe_o     = (kind == BUS_SERIAL) && s_oe;
  assign rd_is_data_o = (kind == BUS_SERIAL) ? s_rs : p_rs;
endmodule

// File: rtl/host_bus_front_chk.sv
module host_bus_front_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          par_mode_i,
  input logic          bus4_i,
  input logic          cs_ni,
  input logic [DW-1:0] db_o,
  input logic          db_oe_o,
  input logic          sio_oe_o,
  input logic          wr_valid_o
);
  localparam int unsigned NW = DW / 2;

  a_r1_serial_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_mode_i |-> !db_oe_o);

  a_r1_parallel_no_sio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i |-> !sio_oe_o);

  a_r2_deselected_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3))
      |-> (!db_oe_o && !sio_oe_o && !wr_valid_o));

  a_r7_low_lines_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus4_i && db_oe_o) |-> (db_o[NW-1:0] == '0));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r1_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(db_oe_o && sio_oe_o));
endmodule

bind host_bus_front host_bus_front_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .par_mode_i(par_mode_i),
  .bus4_i    (bus4_i),
  .cs_ni     (cs_ni),
  .db_o      (db_o),
  .db_oe_o   (db_oe_o),
  .sio_oe_o  (sio_oe_o),
  .wr_valid_o(wr_valid_o)
);

// File: tb/sim_host_bus_front.sv
`timescale 1ns/1ps
module sim_host_bus_front;
  localparam int DW = 8;

  logic clk = 0, rst_ni = 0;
  logic par_mode = 1, m68 = 1, bus4 = 0;
  logic cs_n = 1, rs = 1, e = 0, rw = 0, sio = 0;
  logic [DW-1:0] db = '0, rd_data = '0;
  logic [DW-1:0] db_o, wr_data;
  logic db_oe, sio_o, sio_oe, rd_is_data, wr_valid, wr_is_data;

  always #2 clk = ~clk;  // 250 MHz

  host_bus_front #(.DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .par_mode_i(par_mode), .m68_i(m68), .bus4_i(bus4),
    .cs_ni(cs_n), .rs_i(rs), .e_i(e), .rw_i(rw), .db_i(db), .db_o(db_o), .db_oe_o(db_oe),
    .sio_i(sio), .sio_o(sio_o), .sio_oe_o(sio_oe), .rd_data_i(rd_data),
    .rd_is_data_o(rd_is_data), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .wr_is_data_o(wr_is_data)
  );

  int checks = 0, fails = 0, pulses = 0;
  logic [DW-1:0] last_byte;
  logic last_rs;
  bit done = 0;

  always @(posedge clk) if (wr_valid) begin
    pulses    <= pulses + 1;
    last_byte <= wr_data;
    last_rs   <= wr_is_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_wr(input string req, input int base, input logic [DW-1:0] b, input logic r);
    chk(pulses == base + 1, req, pulses - base, 1);
    chk(last_byte == b && last_rs == r, req, {last_rs, last_byte}, {r, b});
  endtask

  task automatic m68_strobe(input logic r, input logic [DW-1:0] d);
    rs = r; rw = 0; db = d; cs_n = 0; wt(3);
    e = 1; wt(4); e = 0; wt(4); cs_n = 1; wt(3);
  endtask

  task automatic i80_strobe(input logic r, input logic [DW-1:0] d);
    rs = r; db = d; cs_n = 0; wt(3);
    rw = 0; wt(4); rw = 1; wt(4); cs_n = 1; wt(3);
  endtask

  task automatic ser_frame(input logic rd, input logic r, input logic [DW-1:0] d,
                           input int nbits, input string req);
    logic [DW+1:0] fr;
    fr = {rd, r, d};
    cs_n = 0; rs = 0; wt(3);
    for (int i = 0; i < nbits; i++) begin
      sio = (i < DW + 2) ? fr[DW+1-i] : 1'b0;
      if (rd && i >= 2) begin
        chk(sio_oe && sio_o == rd_data[DW+1-i], req, {sio_oe, sio_o}, {1'b1, rd_data[DW+1-i]});
      end
      wt(2); e = 1; wt(5); e = 0; wt(3);
    end
    if (rd) begin
      chk(!sio_oe, req, sio_oe, 0);
      chk(rd_is_data == r, "R12", rd_is_data, r);
    end
    rs = 1; wt(5); cs_n = 1; wt(3);
  endtask

  initial begin
    int base;
    logic [DW-1:0] b;
    wt(4);
    chk(!db_oe && !sio_oe && !wr_valid, "R2 reset", {db_oe, sio_oe, wr_valid}, 0);
    rst_ni = 1; wt(3);

    // R3: M68 8-bit, all bytes
    par_mode = 1; m68 = 1; bus4 = 0; e = 0; rw = 0; wt(4);
    for (int v = 0; v < 256; v++) begin
      base = pulses; b = DW'(v);
      m68_strobe(b[0], b);
      check_wr("R3", base, b, b[0]);
    end
    // R4 M68 read
    for (int v = 0; v < 256; v += 13) begin
      rd_data = DW'(v * 7 + 3); rs = v[0]; rw = 1; cs_n = 0; wt(3); e = 1; wt(5);
      chk(db_oe && db_o == rd_data, "R4", {db_oe, db_o}, {1'b1, rd_data});
      chk(rd_is_data == v[0], "R12", rd_is_data, v[0]);
      e = 0; wt(4); cs_n = 1; rw = 0; wt(3);
      chk(!db_oe, "R4 release", db_oe, 0);
    end
    // R2 cs high
    base = pulses;
    rw = 0; db = 8'h5A; e = 1; wt(4); e = 0; wt(4);
    rw = 1; e = 1; wt(5);
    chk(pulses == base && !db_oe, "R2", {pulses - base, db_oe}, 0);
    e = 0; rw = 0; wt(4);
    // R1: i80 read strobe shape while M68 selected (e low, cs low, rw low): no drive
    cs_n = 0; wt(5);
    chk(!db_oe, "R1 style", db_oe, 0);
    cs_n = 1; wt(3);

    // R5: i80 8-bit, all bytes
    m68 = 0; rw = 1; e = 1; wt(4);
    for (int v = 0; v < 256; v++) begin
      base = pulses; b = DW'(v ^ 8'hA5);
      i80_strobe(~b[0], b);
      check_wr("R5", base, b, ~b[0]);
    end
    // R6 i80 read
    for (int v = 0; v < 256; v += 13) begin
      rd_data = DW'(v * 11 + 1); rs = v[1]; cs_n = 0; wt(3); e = 0; wt(5);
      chk(db_oe && db_o == rd_data, "R6", {db_oe, db_o}, {1'b1, rd_data});
      chk(rd_is_data == v[1], "R12", rd_is_data, v[1]);
      e = 1; wt(4); cs_n = 1; wt(3);
    end

    // R7: i80 4-bit writes
    bus4 = 1; wt(2);
    for (int v = 0; v < 256; v += 7) begin
      b = DW'(v); base = pulses;
      i80_strobe(b[2], {b[7:4], ~b[7:4]});
      chk(pulses == base, "R7 half", pulses - base, 0);
      i80_strobe(b[2], {b[3:0], b[7:4]});
      check_wr("R7", base, b, b[2]);
    end
    // R7 i80 4-bit read
    rd_data = 8'hC3; cs_n = 0; wt(3); e = 0; wt(5);
    chk(db_oe && db_o == 8'hC0, "R7 rd hi", db_o, 8'hC0);
    e = 1; wt(4); e = 0; wt(5);
    chk(db_oe && db_o == 8'h30, "R7 rd lo", db_o, 8'h30);
    e = 1; wt(4); cs_n = 1; wt(3);

    // R7: M68 4-bit writes
    m68 = 1; e = 0; rw = 0; wt(4);
    for (int v = 0; v < 256; v += 7) begin
      b = DW'(v * 3); base = pulses;
      m68_strobe(~b[1], {b[7:4], 4'hF});
      m68_strobe(~b[1], {b[3:0], 4'h0});
      check_wr("R7 m68", base, b, ~b[1]);
    end

    // R8: dangling nibble then reset
    base = pulses;
    m68_strobe(1, 8'hE0);
    rst_ni = 0; wt(2); rst_ni = 1; wt(3);
    base = pulses;
    m68_strobe(1, 8'h90);
    m68_strobe(1, 8'h60);
    check_wr("R8", base, 8'h96, 1);

    // R9: serial writes
    bus4 = 0; par_mode = 0; e = 0; rs = 1; wt(4);
    for (int v = 0; v < 256; v += 5) begin
      b = DW'(v * 9 + 2); base = pulses;
      ser_frame(0, v[0], b, 10, "R9");
      check_wr("R9", base, b, v[0]);
    end
    base = pulses;
    ser_frame(0, 1, 8'h3C, 9, "R9 short");
    chk(pulses == base, "R9 short", pulses - base, 0);
    ser_frame(0, 1, 8'h3C, 11, "R9 long");
    chk(pulses == base, "R9 long", pulses - base, 0);
    // R1: M68 write shape in serial mode: frame strobe high, nothing happens
    m68_strobe(1, 8'h11);
    chk(pulses == base && !db_oe, "R1 serial", pulses - base, 0);

    // R10: serial reads
    for (int v = 0; v < 256; v += 17) begin
      rd_data = DW'(v ^ 8'h6B);
      ser_frame(1, v[0], 8'h00, 10, "R10");
      chk(pulses == base, "R10 no write", pulses - base, 0);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule